// File: doc/BRIEF.md
# SRAM Bank Select Controller

This block sits between a 16-bit processor-side memory port and an external static RAM built as one or two banks, each 16 bits wide with separate low-byte and high-byte select lines. When it takes a request, it finds which bank the byte address falls in and lowers the matching active-low chip selects. It presents the word address, lowers the single write strobe for writes, and acknowledges after a programmable number of wait states.

A small configuration port sets three things: whether the SRAM interface is active at all, a 3-bit code for the total memory size, and a 2-bit wait-state selection. When the interface is disabled, or the access falls outside the configured size, or no byte lane is enabled, the cycle still completes and is acknowledged but no chip select is asserted. The requester holds `req_valid` until it sees `req_ack`. Every request field and configuration value is captured in the cycle the request is accepted.

Top module: `sram_bank_ctl`

## Requirements
- R1: When `cfg_sram_en` is 0 at acceptance, no chip select is asserted and `sram_we_n` stays high for the whole access, yet `req_ack` still arrives after the programmed wait states.
- R2: Size code n gives a total size of 512 Kbyte shifted left by n, capped at 16 Mbyte for n of 5 or more. An access whose byte address is at or above that total asserts no chip select and is still acknowledged.
- R3: With two banks, bank 1 begins at half the total size. `sram_cs_n[0]` is bank 0 low byte, `[1]` bank 0 high byte, `[2]` bank 1 low byte and `[3]` bank 1 high byte. Selects of both banks are never low together.
- R4: `req_be[0]` enables the low byte and `req_be[1]` the high byte. Only the selects of enabled lanes go low, and with neither enabled no select goes low.
- R5: Chip selects are active low. During an access, `sram_addr` carries `req_addr[23:1]` of the accepted request.
- R6: `sram_we_n` is low during every cycle of an accepted write that asserts at least one chip select. It stays high for reads and for writes that assert none.
- R7: A wait code of 0, 1 or 2 gives that many wait states, and code 3 acts as 2. The access outputs are held for W+1 cycles, starting the cycle after the accepting edge. `req_ack` is high for one cycle only, the last of them.
- R8: Changes to configuration or request inputs during an access have no effect on that access.
- R9: After reset, and in the cycle after every acknowledge, all selects are high, `sram_we_n` is high and `req_ack` is low. The next request is accepted no earlier than that idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request pending; held until acknowledged |
| req_addr | input | 24 | Byte address |
| req_be | input | 2 | Byte lane enables (bit 0 low byte, bit 1 high byte) |
| req_write | input | 1 | 1 for write, 0 for read |
| cfg_sram_en | input | 1 | SRAM interface enable |
| cfg_size | input | 3 | Total size code |
| cfg_wait | input | 2 | Wait-state selection |
| req_ack | output | 1 | Access complete, one cycle |
| sram_cs_n | output | 4 | Active-low chip selects, two per bank |
| sram_addr | output | 23 | Word address to the memory |
| sram_we_n | output | 1 | Active-low write enable |

## Verification
A request is taken at the rising edge where `req_valid` is high and the block is idle. Selects, address and write enable change in the cycle right after that edge. `req_ack` rises in the (W+1)-th cycle after it, and the following cycle is idle. The bench drives every input on falling edges and samples at every falling edge across the whole access and the idle cycle after it. Each sample is compared with values its model computes from the requirement arithmetic, so an output that moves one cycle early or late is caught at that sample.

// File: rtl/sram_bank_pkg.sv
`timescale 1ns/1ps
package sram_bank_pkg;
   // two selects per bank, two banks at most
   localparam int SEL_W = 4;

   typedef enum logic [0:0] {
      ST_IDLE   = 1'b0,
      ST_ACCESS = 1'b1
   } sbc_state_e;
endpackage

// File: rtl/sbc_region_decode.sv
`timescale 1ns/1ps
module sbc_region_decode #(
   parameter int ADDR_W    = 24,
   parameter int SIZE_W    = 3,
   parameter int BASE_LOG2 = 19,
   parameter int NUM_BANKS = 2
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [1:0]                      be,
   input  logic [SIZE_W-1:0]               size_code,
   input  logic                            sram_en,
   output logic [sram_bank_pkg::SEL_W-1:0] sel,
   output logic                            hit
);
   localparam int MAX_SHIFT = ADDR_W - BASE_LOG2;
   localparam int IDX_W     = $clog2(ADDR_W) + 1;

   logic [IDX_W-1:0] sh;
   logic [IDX_W-1:0] bank_idx;
   logic             in_range;
   logic             upper;
   logic             bank1;

   always_comb begin
      sh       = (size_code > SIZE_W'(MAX_SHIFT)) ? IDX_W'(MAX_SHIFT) : IDX_W'(size_code);
      in_range = ((addr >> (IDX_W'(BASE_LOG2) + sh)) == '0);
      bank_idx = IDX_W'(BASE_LOG2) + sh - IDX_W'(1);
      upper    = addr[bank_idx];
   end

   generate
      if (NUM_BANKS == 2) begin : g_two_banks
         assign bank1 = upper;
      end else begin : g_one_bank
         logic unused_upper;
         assign unused_upper = upper;
         assign bank1 = 1'b0;
      end
   endgenerate

   assign hit = sram_en & in_range & (|be);
   assign sel = {bank1 & be[1], bank1 & be[0], ~bank1 & be[1], ~bank1 & be[0]}
                & {sram_bank_pkg::SEL_W{hit}};
endmodule

// File: rtl/sbc_wait_timer.sv
`timescale 1ns/1ps
module sbc_wait_timer #(
   parameter int WAIT_W   = 2,
   parameter int MAX_WAIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   input  logic              run,
   output logic              last
);
   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W-1:0] sat_val;

   assign sat_val = (load_val > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= sat_val;
      end else if (run && cnt_q != '0) begin
         cnt_q <= cnt_q - WAIT_W'(1);
      end
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_bank_ctl.sv
`timescale 1ns/1ps
module sram_bank_ctl #(
   parameter int ADDR_W    = 24,
   parameter int SIZE_W    = 3,
   parameter int WAIT_W    = 2,
   parameter int MAX_WAIT  = 2,
   parameter int NUM_BANKS = 2,
   parameter int BASE_LOG2 = 19
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   input  logic [ADDR_W-1:0]               req_addr,
   input  logic [1:0]                      req_be,
   input  logic                            req_write,
   input  logic                            cfg_sram_en,
   input  logic [SIZE_W-1:0]               cfg_size,
   input  logic [WAIT_W-1:0]               cfg_wait,
   output logic                            req_ack,
   output logic [sram_bank_pkg::SEL_W-1:0] sram_cs_n,
   output logic [ADDR_W-2:0]               sram_addr,
   output logic                            sram_we_n
);
   import sram_bank_pkg::*;

   localparam int WORD_W = ADDR_W - 1;

   initial begin
      if (NUM_BANKS < 1 || NUM_BANKS > 2) $error("NUM_BANKS must be 1 or 2");
      if (MAX_WAIT >= (1 << WAIT_W))      $error("MAX_WAIT does not fit WAIT_W");
      if (BASE_LOG2 < 1 || BASE_LOG2 >= ADDR_W) $error("BASE_LOG2 out of range");
      if (ADDR_W - BASE_LOG2 > (1 << SIZE_W) - 1) $error("SIZE_W too narrow");
   end

   sbc_state_e         state_q;
   logic               busy;
   logic               accept;
   logic               last;
   logic               hit;
   logic [SEL_W-1:0]   sel;
   logic [SEL_W-1:0]   cs_n_q;
   logic [WORD_W-1:0]  addr_q;
   logic               we_n_q;

   assign busy   = (state_q == ST_ACCESS);
   assign accept = req_valid & ~busy;

   sbc_region_decode #(
      .ADDR_W   (ADDR_W),
      .SIZE_W   (SIZE_W),
      .BASE_LOG2(BASE_LOG2),
      .NUM_BANKS(NUM_BANKS)
   ) u_decode (
      .addr     (req_addr),
      .be       (req_be),
      .size_code(cfg_size),
      .sram_en  (cfg_sram_en),
      .sel      (sel),
      .hit      (hit)
   );

   sbc_wait_timer #(
      .WAIT_W  (WAIT_W),
      .MAX_WAIT(MAX_WAIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .load_val(cfg_wait),
      .run     (busy),
      .last    (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_n_q  <= '1;
         we_n_q  <= 1'b1;
         addr_q  <= '0;
      end else if (accept) begin
         state_q <= ST_ACCESS;
         cs_n_q  <= ~sel;
         we_n_q  <= ~(req_write & hit);
         addr_q  <= req_addr[ADDR_W-1:1];
      end else if (busy && last) begin
         state_q <= ST_IDLE;
         cs_n_q  <= '1;
         we_n_q  <= 1'b1;
      end
   end

   assign req_ack   = busy & last;
   assign sram_cs_n = cs_n_q;
   assign sram_addr = addr_q;
   assign sram_we_n = we_n_q;
endmodule

// File: rtl/sram_bank_ctl_chk.sv
`timescale 1ns/1ps
module sram_bank_ctl_chk #(
   parameter int WORD_W   = 23,
   parameter int WAIT_W   = 2,
   parameter int MAX_WAIT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              cfg_sram_en,
   input logic [WAIT_W-1:0] cfg_wait,
   input logic              busy,
   input logic              req_ack,
   input logic [3:0]        sram_cs_n,
   input logic [WORD_W-1:0] sram_addr,
   input logic              sram_we_n
);
   logic [WAIT_W:0]   cyc_q;
   logic [WAIT_W-1:0] wlim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         wlim_q <= '0;
      end else if (req_valid && !busy) begin
         cyc_q  <= '0;
         wlim_q <= (cfg_wait > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : cfg_wait;
      end else if (busy) begin
         cyc_q  <= cyc_q + 1'b1;
      end
   end

   p_ack_on_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (req_ack == (cyc_q == {1'b0, wlim_q})));

   p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !cfg_sram_en) |=> (&sram_cs_n && sram_we_n));

   p_banks_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!(&sram_cs_n[1:0]) && !(&sram_cs_n[3:2])));

   p_we_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> !(&sram_cs_n));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !req_ack) |=> ($stable(sram_cs_n) && $stable(sram_addr) && $stable(sram_we_n)));

   p_idle_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> (&sram_cs_n && sram_we_n && !req_ack));
endmodule

bind sram_bank_ctl sram_bank_ctl_chk #(
   .WORD_W  (WORD_W),
   .WAIT_W  (WAIT_W),
   .MAX_WAIT(MAX_WAIT)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .cfg_sram_en(cfg_sram_en),
   .cfg_wait   (cfg_wait),
   .busy       (busy),
   .req_ack    (req_ack),
   .sram_cs_n  (sram_cs_n),
   .sram_addr  (sram_addr),
   .sram_we_n  (sram_we_n)
);

// File: tb/sram_bank_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_bank_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic        req_write = 1'b0;
   logic        cfg_sram_en = 1'b0;
   logic [2:0]  cfg_size = '0;
   logic [1:0]  cfg_wait = '0;
   logic        req_ack;
   logic [3:0]  sram_cs_n;
   logic [22:0] sram_addr;
   logic        sram_we_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sram_bank_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_be(req_be), .req_write(req_write), .cfg_sram_en(cfg_sram_en),
      .cfg_size(cfg_size), .cfg_wait(cfg_wait), .req_ack(req_ack),
      .sram_cs_n(sram_cs_n), .sram_addr(sram_addr), .sram_we_n(sram_we_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic idle_check(input string req);
      chk(req, "idle cs_n", 32'(sram_cs_n), 32'hF);
      chk(req, "idle we_n", 32'(sram_we_n), 32'h1);
      chk(req, "idle ack",  32'(req_ack),   32'h0);
   endtask

   // reference model: computes expected pins per cycle from the requirement arithmetic
   task automatic run_access(input logic [23:0] a, input logic [1:0] be, input logic wr,
                             input logic en, input logic [2:0] sz, input logic [1:0] ws,
                             input bit disturb, input string req);
      int          sh;
      longint      total;
      bit          inr;
      bit          b1;
      logic [3:0]  exp_cs;
      logic        exp_we;
      int          w;
      sh     = (sz > 3'd5) ? 5 : int'(sz);
      total  = longint'(524288) << sh;
      inr    = longint'(a) < total;
      b1     = longint'(a) >= (total / 2);
      exp_cs = 4'hF;
      if (en && inr) begin
         if (be[0]) exp_cs[b1 ? 2 : 0] = 1'b0;
         if (be[1]) exp_cs[b1 ? 3 : 1] = 1'b0;
      end
      exp_we = !(wr && exp_cs != 4'hF);
      w      = (ws == 2'd3) ? 2 : int'(ws);

      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_be = be; req_write = wr;
      cfg_sram_en = en; cfg_size = sz; cfg_wait = ws;
      @(negedge clk);
      for (int i = 0; i <= w; i++) begin
         if (disturb && i == 0) begin
            cfg_sram_en = ~en; cfg_size = ~sz; cfg_wait = 2'd0;
            req_addr = ~a; req_be = ~be; req_write = ~wr;
         end
         chk(req, "cs_n", 32'(sram_cs_n), 32'(exp_cs));
         chk(req, "addr", 32'(sram_addr), 32'(a[23:1]));
         chk(req, "we_n", 32'(sram_we_n), 32'(exp_we));
         chk(req, "ack",  32'(req_ack),   (i == w) ? 32'h1 : 32'h0);
         if (i == w) req_valid = 1'b0;
         @(negedge clk);
      end
      idle_check(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      idle_check("R9");
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R9");

      // R5 R4: word read, bank 0, smallest size, no waits
      run_access(24'h000124, 2'b11, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, "R5");
      // R4 R6: low-byte write with one wait
      run_access(24'h000200, 2'b01, 1'b1, 1'b1, 3'd0, 2'd1, 1'b0, "R6");
      // R3: high byte at start of bank 1 for 512 Kbyte total
      run_access(24'h040000, 2'b10, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, "R3");
      run_access(24'h03FFFE, 2'b10, 1'b1, 1'b1, 3'd0, 2'd0, 1'b0, "R3");
      // R2: 2 Mbyte total
      run_access(24'h100000, 2'b11, 1'b1, 1'b1, 3'd2, 2'd2, 1'b0, "R2");
      run_access(24'h0FFFFE, 2'b01, 1'b0, 1'b1, 3'd2, 2'd2, 1'b0, "R2");
      run_access(24'h200000, 2'b11, 1'b1, 1'b1, 3'd2, 2'd1, 1'b0, "R2");
      run_access(24'h080000, 2'b11, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, "R2");
      // R2 cap: codes 5..7 all mean 16 Mbyte; R7 code 3 acts as 2
      run_access(24'hFFFFFE, 2'b11, 1'b1, 1'b1, 3'd7, 2'd3, 1'b0, "R7");
      run_access(24'h7FFFFE, 2'b01, 1'b0, 1'b1, 3'd5, 2'd2, 1'b0, "R2");
      run_access(24'h800000, 2'b10, 1'b1, 1'b1, 3'd6, 2'd1, 1'b0, "R2");
      run_access(24'h400000, 2'b11, 1'b0, 1'b1, 3'd3, 2'd0, 1'b0, "R2");
      // R4: no byte lane enabled
      run_access(24'h000010, 2'b00, 1'b1, 1'b1, 3'd1, 2'd1, 1'b0, "R4");
      // R1: interface disabled
      run_access(24'h000010, 2'b11, 1'b1, 1'b0, 3'd1, 2'd2, 1'b0, "R1");
      run_access(24'h0C0000, 2'b11, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, "R1");
      // R8: inputs change during the access
      run_access(24'h000400, 2'b11, 1'b1, 1'b1, 3'd0, 2'd2, 1'b1, "R8");
      run_access(24'h0C0000, 2'b01, 1'b0, 1'b1, 3'd1, 2'd1, 1'b1, "R8");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule